// File: doc/BRIEF.md
# PLL Lock-Wait Clock Selector

This block decides which clock drives the processor core while a frequency-multiplying PLL settles. It runs an 8-bit settle counter on the reference input clock. The counter advances only while the core reset input is released. Until the count completes, the core clock output is the reference clock divided by two. After 256 counted reference cycles the output moves to the multiplied clock, which nominally runs at five times the reference rate. The handover is synchronous, and the output shows no pulse narrower than half a multiplied-clock period.

The completion state is sticky. Later assertions and releases of the core reset leave the multiplied clock selected, with no slow period. Only the power-on clear input returns the counter and the completion flag to zero, which arms a new slow period. The multiplied clock comes in as a plain input. A status output reports that the multiplied clock has actually reached the output.

Top module: `pll_lockwait_clksel`

## Requirements
- R1: While `por_n` is low, `cpu_clk` and `mul_active` are 0, and the settle counter, the completion flag and the divide-by-two flop are cleared.
- R2: While the count is incomplete, `cpu_clk` is the reference clock divided by two. Its rising edges are two reference periods apart, and the divider toggles on every reference rising edge.
- R3: The settle counter does not advance on a reference rising edge at which `rst_n` is low.
- R4: After `rst_n` goes high, exactly 256 reference rising edges with `rst_n` high complete the count. `mul_active` is still 0 when sampled just after the 256th edge. The completion flag rises only from a count of all ones.
- R5: The handover never enables both sources at once. `cpu_clk` shows no high or low pulse shorter than half a multiplied-clock period.
- R6: Once the count is complete, the completion flag stays set. Asserting and releasing `rst_n` again keeps `mul_active` at 1 and `cpu_clk` at the multiplied rate, with no slow period.
- R7: Within 14 reference cycles after completion, `mul_active` is 1 and the `cpu_clk` period equals the `mul_clk` period. `mul_active` is 1 only while the completion flag is set.
- R8: Pulsing `por_n` low after completion re-arms the block: the slow divided output returns, and the count then completes again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference input clock; clocks the settle counter and the divider |
| mul_clk | input | 1 | Multiplied clock from the PLL, nominally five times `ref_clk` |
| por_n | input | 1 | Power-on clear, active low, asynchronous assert |
| rst_n | input | 1 | Core reset, active low; it only holds the settle counter |
| cpu_clk | output | 1 | Selected core clock |
| mul_active | output | 1 | High when the multiplied clock is driving `cpu_clk` |

## Verification
On every cycle, the assertions check the following: the settle count holds while reset is low, the completion flag is sticky and is set only from a full count, the divider toggles on each reference edge, the two source enables are never on together, and the status flag never runs ahead of completion. The exact length of the slow period, the measured output periods before and after the handover, and the minimum pulse width on the output can only be shown by the bench's timed scenarios. The same holds for the absence of a slow period on a second reset and for re-arming by power-on clear.

// File: rtl/lwcs_pkg.sv
package lwcs_pkg;
  parameter int unsigned SETTLE_W    = 8;
  parameter int unsigned SYNC_STAGES = 2;
  localparam int unsigned NUM_SRC    = 2;

  typedef enum logic {
    SRC_DIV = 1'b0,
    SRC_MUL = 1'b1
  } src_e;
endpackage

// File: rtl/lwcs_sync2.sv
module lwcs_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;
  logic [STAGES-1:0] shreg_nxt;

  always_comb begin
    shreg_nxt = {shreg[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shreg <= '0;
    else         shreg <= shreg_nxt;
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/lwcs_settle.sv
module lwcs_settle #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         run_n,
  output logic [W-1:0] cnt_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q, cnt_nxt;
  logic         done_q, done_nxt;
  logic [W:0]   sum;
  logic         adv;

  // advance only while core reset is released and the count is open
  assign adv = run_n & ~done_q;
  assign sum = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};

  always_comb begin
    cnt_nxt  = cnt_q;
    done_nxt = done_q;
    if (adv) begin
      cnt_nxt = sum[W-1:0];
      if (sum[W]) done_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      done_q <= done_nxt;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/lwcs_div2.sv
module lwcs_div2 (
  input  logic clk,
  input  logic arst_n,
  output logic q
);
  logic tog_q, tog_nxt;

  always_comb begin
    tog_nxt = ~tog_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) tog_q <= 1'b0;
    else         tog_q <= tog_nxt;
  end

  assign q = tog_q;
endmodule

// File: rtl/lwcs_gfmux.sv
module lwcs_gfmux #(
  parameter int unsigned STAGES = 2
) (
  input  logic                         clk_div,
  input  logic                         clk_mul,
  input  logic                         arst_div_n,
  input  logic                         arst_mul_n,
  input  logic                         sel_mul,
  output logic [lwcs_pkg::NUM_SRC-1:0] en_o,
  output logic                         clk_o
);
  localparam int unsigned N = lwcs_pkg::NUM_SRC;

  logic [N-1:0] src;
  logic [N-1:0] src_n;
  logic [N-1:0] arst_n;
  logic [N-1:0] want;
  logic [N-1:0] en;

  assign src[int'(lwcs_pkg::SRC_DIV)]    = clk_div;
  assign src[int'(lwcs_pkg::SRC_MUL)]    = clk_mul;
  assign arst_n[int'(lwcs_pkg::SRC_DIV)] = arst_div_n;
  assign arst_n[int'(lwcs_pkg::SRC_MUL)] = arst_mul_n;
  assign want[int'(lwcs_pkg::SRC_DIV)]   = ~sel_mul;
  assign want[int'(lwcs_pkg::SRC_MUL)]   = sel_mul;
  assign src_n = ~src;

  // each branch waits for the other branch's enable to drop, then
  // synchronises its request on the falling edge of its own clock
  for (genvar i = 0; i < N; i++) begin : g_branch
    logic req;
    assign req = want[i] & ~en[N-1-i];
    lwcs_sync2 #(.STAGES(STAGES)) u_sync (
      .clk   (src_n[i]),
      .arst_n(arst_n[i]),
      .d     (req),
      .q     (en[i])
    );
  end

  assign clk_o = |(src & en);
  assign en_o  = en;
endmodule

// File: rtl/pll_lockwait_clksel.sv
module pll_lockwait_clksel (
  input  logic ref_clk,
  input  logic mul_clk,
  input  logic por_n,
  input  logic rst_n,
  output logic cpu_clk,
  output logic mul_active
);
  localparam int unsigned W  = lwcs_pkg::SETTLE_W;
  localparam int unsigned SS = lwcs_pkg::SYNC_STAGES;
  localparam int unsigned N  = lwcs_pkg::NUM_SRC;

  logic         por_ref_n;
  logic         por_mul_n;
  logic [W-1:0] settle_cnt;
  logic         settle_done;
  logic         div_clk;
  logic [N-1:0] src_en;

  // power-on clear: asynchronous assert, release synchronised per domain
  lwcs_sync2 #(.STAGES(SS)) u_por_ref (
    .clk(ref_clk), .arst_n(por_n), .d(1'b1), .q(por_ref_n)
  );
  lwcs_sync2 #(.STAGES(SS)) u_por_mul (
    .clk(mul_clk), .arst_n(por_n), .d(1'b1), .q(por_mul_n)
  );

  lwcs_settle #(.W(W)) u_settle (
    .clk   (ref_clk),
    .arst_n(por_ref_n),
    .run_n (rst_n),
    .cnt_o (settle_cnt),
    .done_o(settle_done)
  );

  lwcs_div2 u_div (
    .clk   (ref_clk),
    .arst_n(por_ref_n),
    .q     (div_clk)
  );

  lwcs_gfmux #(.STAGES(SS)) u_mux (
    .clk_div   (div_clk),
    .clk_mul   (mul_clk),
    .arst_div_n(por_ref_n),
    .arst_mul_n(por_mul_n),
    .sel_mul   (settle_done),
    .en_o      (src_en),
    .clk_o     (cpu_clk)
  );

  assign mul_active = src_en[int'(lwcs_pkg::SRC_MUL)];
endmodule

// File: rtl/lwcs_checker.sv
module lwcs_checker #(
  parameter int unsigned W = 8
) (
  input logic         ref_clk,
  input logic         mul_clk,
  input logic         rst_n,
  input logic         por_ref_n,
  input logic         por_mul_n,
  input logic [W-1:0] settle_cnt,
  input logic         settle_done,
  input logic         div_clk,
  input logic [1:0]   src_en,
  input logic         mul_active
);
  // R3: count frozen across an edge where core reset was low
  assert_hold_in_reset_R3: assert property (@(posedge ref_clk) disable iff (!por_ref_n)
    !$past(rst_n) |-> $stable(settle_cnt));

  // R6: completion flag never falls without power-on clear
  assert_sticky_done_R6: assert property (@(posedge ref_clk) disable iff (!por_ref_n)
    $past(settle_done) |-> settle_done);

  // R4: completion only from a full count
  assert_done_from_full_R4: assert property (@(posedge ref_clk) disable iff (!por_ref_n)
    $rose(settle_done) |-> ($past(settle_cnt) == {W{1'b1}}));

  // R2: divider toggles on each reference edge
  assert_div_toggles_R2: assert property (@(posedge ref_clk) disable iff (!por_ref_n)
    $past(por_ref_n) |-> (div_clk != $past(div_clk)));

  // R5: break-before-make between the two sources
  assert_one_source_R5: assert property (@(posedge mul_clk) disable iff (!por_mul_n)
    $countones(src_en) <= 1);

  // R7: status never ahead of completion
  assert_active_needs_done_R7: assert property (@(posedge mul_clk) disable iff (!por_mul_n)
    mul_active |-> settle_done);
endmodule

bind pll_lockwait_clksel lwcs_checker #(.W(lwcs_pkg::SETTLE_W)) u_chk (
  .ref_clk    (ref_clk),
  .mul_clk    (mul_clk),
  .rst_n      (rst_n),
  .por_ref_n  (por_ref_n),
  .por_mul_n  (por_mul_n),
  .settle_cnt (settle_cnt),
  .settle_done(settle_done),
  .div_clk    (div_clk),
  .src_en     (src_en),
  .mul_active (mul_active)
);

// File: tb/pll_lockwait_clksel_bench.sv
`timescale 1ns/1ps
module pll_lockwait_clksel_bench;
  logic ref_clk, mul_clk, por_n, rst_n;
  logic cpu_clk, mul_active;

  pll_lockwait_clksel u_pll_lockwait_clksel (
    .ref_clk(ref_clk), .mul_clk(mul_clk), .por_n(por_n), .rst_n(rst_n),
    .cpu_clk(cpu_clk), .mul_active(mul_active)
  );

  localparam real REF_T = 10.0;
  localparam real MUL_T = 2.0;

  initial begin ref_clk = 1'b0; forever #(REF_T/2) ref_clk = ~ref_clk; end
  initial begin mul_clk = 1'b0; #0.5; forever #(MUL_T/2) mul_clk = ~mul_clk; end

  typedef struct {
    int    at;
    bit    exp_act;
    real   exp_per;
    string tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  int    glitches = 0;
  real   last_rise = 0.0, last_per = 0.0, last_edge = 0.0, min_w = 1.0e9;
  bit    mon_on = 1'b0;
  bit    done_flag = 1'b0;

  task automatic chk(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic expect_after(input int n, input bit act, input real per, input string tag);
    item_t it;
    it.at = cyc + n; it.exp_act = act; it.exp_per = per; it.tag = tag;
    q.push_back(it);
  endtask

  // output observation
  always @(posedge cpu_clk) begin
    last_per  = $realtime - last_rise;
    last_rise = $realtime;
  end

  always @(cpu_clk) begin
    if (mon_on) begin
      if ($realtime - last_edge < min_w) min_w = $realtime - last_edge;
      if ($realtime - last_edge < MUL_T/2 - 0.001) glitches++;
    end
    last_edge = $realtime;
  end

  // scoreboard monitor: sample 2 ns after each reference rising edge
  always @(posedge ref_clk) begin
    cyc++;
    #2;
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      it = q.pop_front();
      chk(mul_active == it.exp_act, {it.tag, " mul_active"},
          $sformatf("%0b", mul_active), $sformatf("%0b", it.exp_act));
      chk((last_per > it.exp_per - 0.05) && (last_per < it.exp_per + 0.05),
          {it.tag, " period"}, $sformatf("%0.3f", last_per), $sformatf("%0.3f", it.exp_per));
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0;
    repeat (4) @(negedge ref_clk);
    // R1: power-on clear state
    chk(cpu_clk == 1'b0, "R1 cpu_clk in clear", $sformatf("%0b", cpu_clk), "0");
    chk(mul_active == 1'b0, "R1 mul_active in clear", $sformatf("%0b", mul_active), "0");
    por_n = 1'b1;
    mon_on = 1'b1; last_edge = $realtime;

    // R3: long core reset must not advance the count; R2 slow output
    expect_after(200, 1'b0, 2*REF_T, "R2 slow in reset");
    expect_after(299, 1'b0, 2*REF_T, "R3 no count in reset");
    repeat (300) @(negedge ref_clk);
    rst_n = 1'b1;

    // R4: exactly 256 counted edges
    expect_after(200, 1'b0, 2*REF_T, "R2 slow after release");
    expect_after(255, 1'b0, 2*REF_T, "R4 edge 255 still slow");
    expect_after(256, 1'b0, 2*REF_T, "R4 edge 256 not yet active");
    expect_after(270, 1'b1, MUL_T,   "R7 multiplied after handover");
    repeat (300) @(negedge ref_clk);

    // R6: second reset, no slow period
    rst_n = 1'b0;
    expect_after(10, 1'b1, MUL_T, "R6 fast during reset");
    repeat (20) @(negedge ref_clk);
    rst_n = 1'b1;
    expect_after(3,   1'b1, MUL_T, "R6 fast right after release");
    expect_after(150, 1'b1, MUL_T, "R6 fast later");
    repeat (200) @(negedge ref_clk);

    // R8: power-on clear re-arms
    mon_on = 1'b0;
    por_n = 1'b0;
    repeat (3) @(negedge ref_clk);
    chk(cpu_clk == 1'b0, "R1 cpu_clk in second clear", $sformatf("%0b", cpu_clk), "0");
    chk(mul_active == 1'b0, "R1 mul_active in second clear", $sformatf("%0b", mul_active), "0");
    por_n = 1'b1;
    last_edge = $realtime; mon_on = 1'b1;
    expect_after(100, 1'b0, 2*REF_T, "R8 slow again");
    expect_after(280, 1'b1, MUL_T,   "R8 fast again");
    repeat (300) @(negedge ref_clk);

    // R5: no narrow pulse across all handovers
    chk(glitches == 0, "R5 pulse width", $sformatf("min %0.3f ns", min_w),
        $sformatf(">= %0.3f ns", MUL_T/2));
    chk(q.size() == 0, "R4 scoreboard drained", $sformatf("%0d", q.size()), "0");
    done_flag = 1'b1;
    summary();
    $finish;
  end
endmodule